// File: doc/BRIEF.md
# Register-Access Command Frame Decoder

This block sits on the slave side of a two-wire serial management bus. A front end, not part of this block, deserializes the line. It hands over one assembled 12-bit frame word per strobe. The decoder compares the frame's slave-address nibble with its own configured ID. It then classifies the 8-bit command and steps through any data frames that follow. From these it produces single-cycle write or read strobes toward an 8-bit-wide register file with a 16-bit address space.

Three address forms are handled, and all of them land in the same 16-bit space with the missing upper bits set to zero. A short form carries a 5-bit address inside the command itself. An extended form sends an 8-bit start address in the first data frame. A long form sends a 16-bit start address in two data frames, high byte first. The extended and long forms carry a byte count and run a burst over consecutive register addresses. Write bursts consume one data frame per register. Read bursts issue their read strobes on back-to-back cycles without further frames.

Top module: `regcmd_decoder`

## Requirements
- R1: While reset is high and in the first cycle after it, `reg_we`, `reg_re`, `reg_addr` and `reg_wdata` are all zero and the decoder waits for a command frame.
- R2: When waiting for a command, a frame is a command frame: bits [11:8] are the target slave address and bits [7:0] the command. If bits [11:8] differ from `slv_id`, the frame is dropped with no strobe and the decoder keeps waiting for a command.
- R3: Command 0x40–0x5F (bits [7:5] = 010) is a register write to address bits [4:0] zero-extended to 16 bits. The next frame is a data frame whose bits [7:0] are written; bits [11:8] of a data frame are ignored.
- R4: Command 0x60–0x7F (bits [7:5] = 011) raises `reg_re` once with address bits [4:0] zero-extended, and no data frame is consumed.
- R5: Command 0x80–0xFF (bit 7 = 1) raises `reg_we` once at address 0 with write data {0, command bits [6:0]}.
- R6: Command 0x00–0x0F is an extended write. N = bits [3:0] + 1 registers are written. The first data frame gives the 8-bit start address (upper byte zero), and the next N data frames give the data.
- R7: Command 0x20–0x2F is an extended read of N = bits [3:0] + 1 registers. It takes one address frame. After that frame, `reg_re` is high for N consecutive cycles, and frames that arrive during those cycles are ignored.
- R8: Commands 0x30–0x37 (long write) and 0x38–0x3F (long read) use N = bits [2:0] + 1. Two data frames give the start address, high byte first. The data or read phase then proceeds as in R6 and R7.
- R9: The registers of a burst are accessed in order from the start address, each address one above the previous, wrapping from 0xFFFF to 0x0000.
- R10: Commands 0x10–0x1F are ignored. No strobe follows, and the decoder keeps waiting for a command.
- R11: `reg_we` and `reg_re` are never high together. A strobe produced by an accepted frame appears in the clock cycle right after the edge that accepted it. Each write strobe follows a cycle with `frm_vld` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_vld | input | 1 | One-cycle strobe: `frm_word` holds a complete frame |
| frm_word | input | 12 | Assembled frame; [11:8] slave address in command frames, [7:0] command or data byte |
| slv_id | input | 4 | Local slave ID |
| reg_addr | output | 16 | Register address of the current strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_we` |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read request |

## Verification
Directed frames cover each command class once at a boundary value. These include the top short address 0x1F, the command value 0xFF for the register-0 write, the largest extended burst starting at 0xFE (which crosses into the upper byte), a long write at 0xFFFF (which shows the wrap), and an unused code. They tell apart a wrong code boundary, a missing zero-extension, a byte-order swap in long addresses and an off-by-one in the count. One directed run sends frames during a read burst to show that they are ignored. The ID-mismatch frames show that filtering happens only on the command frame. After that, several hundred random transactions with random IDs, counts and inter-frame gaps (including back-to-back frames) are compared strobe by strobe against a reference model. This exposes sequencing errors that appear only when frames arrive without idle cycles between them.

// File: rtl/regcmd_pkg.sv
`timescale 1ns/1ps
package regcmd_pkg;

    localparam int SID_W   = 4;
    localparam int CMD_W   = 8;
    localparam int DAT_W   = 8;
    localparam int FRM_W   = SID_W + CMD_W;
    localparam int ADR_W   = 2 * DAT_W;
    localparam int BC_W    = 4;
    localparam int CNT_W   = BC_W + 1;
    localparam int SHORT_W = 5;

    typedef enum logic [2:0] {
        K_NONE, K_WR, K_RD, K_W0, K_EWR, K_ERD, K_LWR, K_LRD
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_AHI, S_ALO, S_WDATA, S_RBURST
    } st_e;

    typedef struct packed {
        kind_e              kind;
        logic [CNT_W-1:0]   cnt;
        logic [SHORT_W-1:0] sa;
    } cls_t;

    function automatic logic [CNT_W-1:0] bc_to_cnt(input logic [BC_W-1:0] bc);
        return {1'b0, bc} + CNT_W'(1);
    endfunction

    function automatic logic [ADR_W-1:0] short_addr(input logic [SHORT_W-1:0] sa);
        return {{(ADR_W-SHORT_W){1'b0}}, sa};
    endfunction

endpackage

// File: rtl/regcmd_classify.sv
`timescale 1ns/1ps
module regcmd_classify
    import regcmd_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output cls_t             cls
);
    always_comb begin
        cls.kind = K_NONE;
        cls.cnt  = CNT_W'(1);
        cls.sa   = cmd[SHORT_W-1:0];
        casez (cmd)
            8'b1???_????: cls.kind = K_W0;
            8'b011?_????: cls.kind = K_RD;
            8'b010?_????: cls.kind = K_WR;
            8'b0011_1???: begin
                cls.kind = K_LRD;
                cls.cnt  = bc_to_cnt({1'b0, cmd[2:0]});
            end
            8'b0011_0???: begin
                cls.kind = K_LWR;
                cls.cnt  = bc_to_cnt({1'b0, cmd[2:0]});
            end
            8'b0010_????: begin
                cls.kind = K_ERD;
                cls.cnt  = bc_to_cnt(cmd[BC_W-1:0]);
            end
            8'b0000_????: begin
                cls.kind = K_EWR;
                cls.cnt  = bc_to_cnt(cmd[BC_W-1:0]);
            end
            default: cls.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/regcmd_burst.sv
`timescale 1ns/1ps
module regcmd_burst #(
    parameter int AW = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_cnt,
    input  logic [CW-1:0] cnt_in,
    input  logic          ld_addr,
    input  logic [AW-1:0] addr_in,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic          last
);
    logic [CW-1:0] cnt_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_left <= '0;
            cur_addr <= '0;
        end else begin
            if (ld_cnt)  cnt_left <= cnt_in;
            if (ld_addr) cur_addr <= addr_in;
            if (step) begin
                cnt_left <= cnt_left - CW'(1);
                cur_addr <= cur_addr + AW'(1);
            end
        end
    end

    assign last = (cnt_left == CW'(1));
endmodule

// File: rtl/regcmd_decoder.sv
`timescale 1ns/1ps
module regcmd_decoder
    import regcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_vld,
    input  logic [FRM_W-1:0] frm_word,
    input  logic [SID_W-1:0] slv_id,
    output logic [ADR_W-1:0] reg_addr,
    output logic [DAT_W-1:0] reg_wdata,
    output logic             reg_we,
    output logic             reg_re
);
    st_e              st, st_n;
    cls_t             cls;
    logic [DAT_W-1:0] hi, hi_n, byte_in;
    logic             is_wr, wr_n;
    logic             we_n, re_n;
    logic [ADR_W-1:0] addr_n;
    logic [DAT_W-1:0] wd_n;
    logic             accept;

    logic             ld_cnt, ld_addr, step, last;
    logic [CNT_W-1:0] cnt_in;
    logic [ADR_W-1:0] addr_in, cur_addr;

    assign byte_in = frm_word[DAT_W-1:0];
    assign accept  = frm_vld && (frm_word[FRM_W-1:CMD_W] == slv_id);

    regcmd_classify u_cls (
        .cmd (frm_word[CMD_W-1:0]),
        .cls (cls)
    );

    regcmd_burst #(.AW(ADR_W), .CW(CNT_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .ld_cnt   (ld_cnt),
        .cnt_in   (cnt_in),
        .ld_addr  (ld_addr),
        .addr_in  (addr_in),
        .step     (step),
        .cur_addr (cur_addr),
        .last     (last)
    );

    always_comb begin
        st_n    = st;
        hi_n    = hi;
        wr_n    = is_wr;
        we_n    = 1'b0;
        re_n    = 1'b0;
        addr_n  = reg_addr;
        wd_n    = reg_wdata;
        ld_cnt  = 1'b0;
        cnt_in  = cls.cnt;
        ld_addr = 1'b0;
        addr_in = {hi, byte_in};
        step    = 1'b0;
        unique case (st)
            S_IDLE: if (accept) begin
                unique case (cls.kind)
                    K_WR: begin
                        ld_cnt  = 1'b1;
                        ld_addr = 1'b1;
                        addr_in = short_addr(cls.sa);
                        wr_n    = 1'b1;
                        st_n    = S_WDATA;
                    end
                    K_RD: begin
                        re_n   = 1'b1;
                        addr_n = short_addr(cls.sa);
                    end
                    K_W0: begin
                        we_n   = 1'b1;
                        addr_n = '0;
                        wd_n   = {1'b0, byte_in[DAT_W-2:0]};
                    end
                    K_EWR, K_ERD: begin
                        ld_cnt = 1'b1;
                        hi_n   = '0;
                        wr_n   = (cls.kind == K_EWR);
                        st_n   = S_ALO;
                    end
                    K_LWR, K_LRD: begin
                        ld_cnt = 1'b1;
                        wr_n   = (cls.kind == K_LWR);
                        st_n   = S_AHI;
                    end
                    default: ;
                endcase
            end
            S_AHI: if (frm_vld) begin
                hi_n = byte_in;
                st_n = S_ALO;
            end
            S_ALO: if (frm_vld) begin
                ld_addr = 1'b1;
                st_n    = is_wr ? S_WDATA : S_RBURST;
            end
            S_WDATA: if (frm_vld) begin
                we_n   = 1'b1;
                addr_n = cur_addr;
                wd_n   = byte_in;
                step   = 1'b1;
                if (last) st_n = S_IDLE;
            end
            S_RBURST: begin
                re_n   = 1'b1;
                addr_n = cur_addr;
                step   = 1'b1;
                if (last) st_n = S_IDLE;
            end
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            hi        <= '0;
            is_wr     <= 1'b0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else begin
            st        <= st_n;
            hi        <= hi_n;
            is_wr     <= wr_n;
            reg_we    <= we_n;
            reg_re    <= re_n;
            reg_addr  <= addr_n;
            reg_wdata <= wd_n;
        end
    end
endmodule

// File: rtl/regcmd_decoder_chk.sv
`timescale 1ns/1ps
module regcmd_decoder_chk
    import regcmd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             frm_vld,
    input logic [FRM_W-1:0] frm_word,
    input logic [SID_W-1:0] slv_id,
    input logic [ADR_W-1:0] reg_addr,
    input logic [DAT_W-1:0] reg_wdata,
    input logic             reg_we,
    input logic             reg_re,
    input st_e              st
);
    logic cmd_hit;
    assign cmd_hit = (st == S_IDLE) && frm_vld && (frm_word[FRM_W-1:CMD_W] == slv_id);

    p_sid_filter_r2: assert property (@(posedge clk) disable iff (rst)
        ((st == S_IDLE) && frm_vld && (frm_word[FRM_W-1:CMD_W] != slv_id))
        |=> (!reg_we && !reg_re));

    p_wr_waits_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_hit && (frm_word[7:5] == 3'b010)) |=> (!reg_we && !reg_re));

    p_reg0_write_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_hit && frm_word[7])
        |=> (reg_we && (reg_addr == '0) && (reg_wdata == {1'b0, $past(frm_word[6:0])})));

    p_burst_step_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_re && $past(reg_re) && ($past(st) == S_RBURST) && ($past(st, 2) == S_RBURST))
        |-> (reg_addr == ADR_W'($past(reg_addr) + 1)));

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

    p_we_needs_frame_r11: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(frm_vld));
endmodule

bind regcmd_decoder regcmd_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frm_vld   (frm_vld),
    .frm_word  (frm_word),
    .slv_id    (slv_id),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .st        (st)
);

// File: tb/tb_regcmd_decoder.sv
`timescale 1ns/1ps
module tb_regcmd_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_vld = 1'b0;
    logic [11:0] frm_word = '0;
    logic [3:0]  slv_id = 4'h5;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_we, reg_re;

    always #4 clk = ~clk;

    regcmd_decoder dut (
        .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm_word(frm_word),
        .slv_id(slv_id), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re)
    );

    typedef struct {
        bit          we;
        logic [15:0] a;
        logic [7:0]  d;
        string       tag;
    } ev_t;

    ev_t q[$];
    int  nvec = 0;
    int  nfail = 0;
    bit  done = 0;

    // reference model state
    int          m_st = 0;
    bit          m_wr = 0;
    int          m_cnt = 0;
    logic [7:0]  m_hi = '0;
    logic [15:0] m_addr = '0;
    string       m_tag = "R6";

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic void push(input bit we, input logic [15:0] a,
                                 input logic [7:0] d, input string tag);
        ev_t e;
        e.we = we; e.a = a; e.d = d; e.tag = tag;
        q.push_back(e);
    endfunction

    function automatic void mdl(input logic [11:0] w);
        logic [7:0]  b;
        logic [15:0] a;
        b = w[7:0];
        case (m_st)
            0: if (w[11:8] == slv_id) begin
                casez (b)
                    8'b1???????: push(1, 16'h0, {1'b0, b[6:0]}, "R5");
                    8'b011?????: push(0, {11'h0, b[4:0]}, 8'h0, "R4");
                    8'b010?????: begin
                        m_st = 3; m_addr = {11'h0, b[4:0]}; m_cnt = 1; m_wr = 1; m_tag = "R3";
                    end
                    8'b00111???: begin m_st = 1; m_cnt = b[2:0] + 1; m_wr = 0; m_tag = "R8"; end
                    8'b00110???: begin m_st = 1; m_cnt = b[2:0] + 1; m_wr = 1; m_tag = "R8"; end
                    8'b0010????: begin m_st = 2; m_hi = 0; m_cnt = b[3:0] + 1; m_wr = 0; m_tag = "R7"; end
                    8'b0000????: begin m_st = 2; m_hi = 0; m_cnt = b[3:0] + 1; m_wr = 1; m_tag = "R6"; end
                    default: ;
                endcase
            end
            1: begin m_hi = b; m_st = 2; end
            2: begin
                a = {m_hi, b};
                if (m_wr) begin
                    m_addr = a; m_st = 3;
                end else begin
                    for (int i = 0; i < m_cnt; i++) begin
                        push(0, a, 8'h0, m_tag);
                        a = a + 16'd1;
                    end
                    m_st = 0;
                end
            end
            default: begin
                push(1, m_addr, b, m_tag);
                m_addr = m_addr + 16'd1;
                m_cnt--;
                if (m_cnt == 0) m_st = 0;
            end
        endcase
    endfunction

    // strobe monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst && !done && (reg_we || reg_re)) begin
            if (q.size() == 0) begin
                chk(0, "R2/R10", "unexpected strobe addr", int'(reg_addr), -1);
            end else begin
                ev_t e;
                e = q.pop_front();
                chk((reg_we == e.we) && (reg_re == !e.we) && (reg_addr == e.a) &&
                    (!e.we || (reg_wdata == e.d)),
                    e.tag, "strobe {we,addr,data}",
                    int'({reg_we, reg_addr, reg_wdata}), int'({e.we, e.a, e.d}));
            end
        end
    end

    task automatic send(input logic [11:0] w);
        @(negedge clk);
        frm_vld  = 1'b1;
        frm_word = w;
        mdl(w);
        @(posedge clk);
        #1 frm_vld = 1'b0;
    endtask

    task automatic send_raw(input logic [11:0] w);
        @(negedge clk);
        frm_vld  = 1'b1;
        frm_word = w;
        @(posedge clk);
        #1 frm_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        idle(20);
        chk(q.size() == 0, tag, "pending strobes", q.size(), 0);
        q.delete();
    endtask

    function automatic logic [11:0] dfrm(input logic [7:0] b);
        return {4'($urandom), b};
    endfunction

    task automatic rand_txn();
        int  k;
        bit  hit;
        logic [3:0]  id;
        logic [7:0]  c;
        int  n;
        k   = $urandom_range(0, 7);
        hit = ($urandom_range(0, 4) != 0);
        id  = hit ? slv_id : (slv_id ^ 4'($urandom_range(1, 15)));
        case (k)
            0: c = {3'b010, 5'($urandom)};
            1: c = {3'b011, 5'($urandom)};
            2: c = {1'b1, 7'($urandom)};
            3: c = {4'b0000, 4'($urandom)};
            4: c = {4'b0010, 4'($urandom)};
            5: c = {5'b00110, 3'($urandom)};
            6: c = {5'b00111, 3'($urandom)};
            default: c = {4'b0001, 4'($urandom)};
        endcase
        send({id, c});
        if (hit) begin
            n = 0;
            case (k)
                0: n = 1;
                3: n = 1 + c[3:0] + 1;
                4: n = 1;
                5: n = 2 + c[2:0] + 1;
                6: n = 2;
                default: n = 0;
            endcase
            for (int i = 0; i < n; i++) begin
                if ($urandom_range(0, 1) == 1) idle(1);
                send(dfrm(8'($urandom)));
            end
        end
        drain("R9");
    endtask

    initial begin
        #(8 * 150000);
        chk(0, "R11", "watchdog expired", 0, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(reg_we == 0, "R1", "reg_we after reset", reg_we, 0);
        chk(reg_re == 0, "R1", "reg_re after reset", reg_re, 0);
        chk(reg_addr == 0, "R1", "reg_addr after reset", reg_addr, 0);
        chk(reg_wdata == 0, "R1", "reg_wdata after reset", reg_wdata, 0);

        // R3 + R11 timing: register write at top short address
        send({slv_id, 8'h5F});
        send(12'h0A5);
        @(negedge clk);
        chk(reg_we == 1, "R11", "we one cycle after data frame", reg_we, 1);
        drain("R3");

        // R2: wrong ID, data frame carries an ID that also mismatches
        send({slv_id ^ 4'h3, 8'h41});
        send({slv_id ^ 4'h1, 8'h77});
        drain("R2");

        // R4 + R11: register read, strobe in the next cycle
        send({slv_id, 8'h63});
        @(negedge clk);
        chk(reg_re == 1, "R4", "re one cycle after command", reg_re, 1);
        drain("R4");

        // R5: register-0 write with largest code
        send({slv_id, 8'hFF});
        drain("R5");

        // R6: extended write, count 3, start 0xF0
        send({slv_id, 8'h02});
        send(12'h0F0);
        send(12'h011); send(12'hF22); send(12'h533);
        drain("R6");

        // R7 + R9: extended read of 16 from 0xFE crosses into upper byte
        send({slv_id, 8'h2F});
        send(12'h0FE);
        send_raw({slv_id, 8'hC4});   // arrives during the burst: ignored
        send_raw({slv_id, 8'h61});
        drain("R7");

        // R8 + R9: long write wrapping at 0xFFFF
        send({slv_id, 8'h31});
        send(12'h0FF); send(12'h0FF);
        send(12'h0AA); send(12'h055);
        drain("R8");

        // R8: long read of 8 from 0x1234, high byte first
        send({slv_id, 8'h3F});
        send(12'h012); send(12'h034);
        drain("R8");

        // R10: unused code, then a data-like frame with a foreign ID
        send({slv_id, 8'h15});
        send({slv_id ^ 4'h2, 8'h40});
        drain("R10");

        // back-to-back frames, no idle between
        send({slv_id, 8'h01});
        send(12'h010); send(12'h0C1); send(12'h0C2);
        send({slv_id, 8'h85});
        drain("R11");

        // random
        void'($urandom(32'd1234));
        for (int t = 0; t < 400; t++) rand_txn();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule